// File: doc/BRIEF.md
# Dual-Address Serial Configuration Slave

This block is a two-wire serial bus slave that sits on a configuration bus and answers two 7-bit device addresses. Each address leads to its own 256-byte configuration bank. One bank behaves like persistent storage: its writes are gated by a write-protect input, and each commit is followed by a modelled busy interval. The other bank is volatile and accepts writes at once. The bus lines are sampled in the system clock domain, and the slave pulls the data line low through an open-drain style output.

A master writes a word address and then up to a page of data bytes. It reads back with current-address, random or sequential reads. Both banks share a single address pointer. Written bytes are first gathered in a page buffer. They are applied to the selected bank only when a STOP arrives, so a repeated START leaves the bank untouched.

Top module: `dualbank_cfg_slave`

## Requirements
- R1: After reset the slave releases the data line (`sdaLowOut`=0), `busyOut` is 0 and every byte of both banks reads as 8'h00.
- R2: A device-address byte whose upper seven bits are 7'b1101000 selects the persistent bank and 7'b1101001 selects the volatile bank. Bit 0 is 1 for read and 0 for write. A matching address is acknowledged by driving the data line low during the ninth clock. Any other address is not acknowledged, and the slave ignores the rest of the frame until the next START. The two banks hold separate contents.
- R3: In a write frame, the byte after the device address sets the word address and is acknowledged. Each following data byte is acknowledged and stored at the pointer.
- R4: During a write, only the low four pointer bits advance. A 17th byte in one frame overwrites the first byte of the same 16-byte page, and no byte outside that page changes.
- R5: Received bytes reach a bank only at STOP. A repeated START discards them, but the word address it set is kept in the pointer.
- R6: A STOP that commits at least one byte to the persistent bank raises `busyOut` for exactly BUSY_CYCLES clock cycles. During that time no device address is acknowledged. Volatile commits never raise `busyOut`.
- R7: While `wpIn` is 1, persistent-bank writes are still acknowledged normally, but no commit happens and `busyOut` stays 0.
- R8: The pointer holds one more than the last byte accessed, and a current-address read returns the byte at the pointer.
- R9: In a read, each master ACK moves the pointer forward and sends the next byte, wrapping from 8'hFF to 8'h00 in the same bank. A master NACK ends the transfer.
- R10: START is the data line falling while the clock is high, and STOP is the data line rising while the clock is high. The slave changes its data drive only while the clock is low, and it releases the line after a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line, asynchronous |
| sdaIn | input | 1 | Serial data line as seen on the bus, asynchronous |
| wpIn | input | 1 | Write protect for the persistent bank, active high |
| sdaLowOut | output | 1 | 1 pulls the data line low, 0 releases it |
| busyOut | output | 1 | Persistent-bank commit interval in progress |

## Verification
A corrupted bit counter or state shows up within one byte as a missing or misplaced acknowledge, or as shifted read data. A wrong pointer or page-buffer state is silent until the next read, which then returns bytes from the wrong address. Wrong page wrapping is seen only when a later sequential read covers the whole page and the first byte past it. Errors in the busy counter or the commit gating show at the ports within a few cycles of STOP, as `busyOut` values or acknowledge behaviour that do not match what is expected.

// File: rtl/cfgslv_pkg.sv
`timescale 1ns/1ps
package cfgslv_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WRITE,
    ST_READ
  } busState_t;

  // strobes from the bus control to the storage datapath
  typedef struct packed {
    logic              setPtr;
    logic              storeByte;
    logic              advPtr;
    logic              commit;
    logic              discard;
    logic [BYTE_W-1:0] byteVal;
  } ctrlStb_t;
endpackage

// File: rtl/cfgslv_ctrl.sv
`timescale 1ns/1ps
module cfgslv_ctrl import cfgslv_pkg::*; #(
  parameter logic [6:0] NV_DEV  = 7'b1101000,
  parameter logic [6:0] VOL_DEV = 7'b1101001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rdData,
  output ctrlStb_t          stb,
  output logic              bankNv,
  output logic              sdaLow,
  output logic              sclS
);
  logic [1:0] sclSyn, sdaSyn;
  logic sdaS, sclD, sdaD;
  logic sclRise, sclFall, startC, stopC;
  busState_t state;
  logic [3:0] bitCnt;
  logic [BYTE_W-1:0] shiftR, txR;
  logic mAck, devHit, loadTx;

  assign sclS = sclSyn[1];
  assign sdaS = sdaSyn[1];
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startC  = sclS & sclD & sdaD & ~sdaS;
  assign stopC   = sclS & sclD & ~sdaD & sdaS;
  assign devHit  = ((shiftR[7:1] == NV_DEV) || (shiftR[7:1] == VOL_DEV)) && !busy;
  assign loadTx  = sclFall && (bitCnt == 4'd9) &&
                   (((state == ST_DEV) && shiftR[0]) || ((state == ST_READ) && mAck));

  always_comb begin
    stb           = '0;
    stb.byteVal   = shiftR;
    stb.discard   = startC;
    stb.commit    = stopC;
    stb.setPtr    = sclFall && (bitCnt == 4'd8) && (state == ST_WORD);
    stb.storeByte = sclFall && (bitCnt == 4'd8) && (state == ST_WRITE);
    stb.advPtr    = loadTx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSyn <= 2'b11;
      sdaSyn <= 2'b11;
      sclD   <= 1'b1;
      sdaD   <= 1'b1;
      state  <= ST_IDLE;
      bitCnt <= '0;
      shiftR <= '0;
      txR    <= '0;
      mAck   <= 1'b0;
      bankNv <= 1'b0;
      sdaLow <= 1'b0;
    end else begin
      sclSyn <= {sclSyn[0], sclIn};
      sdaSyn <= {sdaSyn[0], sdaIn};
      sclD   <= sclS;
      sdaD   <= sdaS;
      if (startC) begin
        state  <= ST_DEV;
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end else if (stopC) begin
        state  <= ST_IDLE;
        sdaLow <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sclRise) begin
          if (bitCnt < 4'd8) begin
            shiftR <= {shiftR[BYTE_W-2:0], sdaS};
            bitCnt <= bitCnt + 4'd1;
          end else if (bitCnt == 4'd8) begin
            bitCnt <= 4'd9;
            mAck   <= ~sdaS;
          end
        end
        if (sclFall) begin
          if (bitCnt == 4'd8) begin
            if (state == ST_READ) sdaLow <= 1'b0;
            else if (state == ST_DEV) begin
              if (devHit) begin
                sdaLow <= 1'b1;
                bankNv <= (shiftR[7:1] == NV_DEV);
              end else begin
                state <= ST_IDLE;
              end
            end else sdaLow <= 1'b1;
          end else if (bitCnt == 4'd9) begin
            sdaLow <= 1'b0;
            bitCnt <= '0;
            if (loadTx) begin
              state  <= ST_READ;
              txR    <= rdData;
              sdaLow <= ~rdData[BYTE_W-1];
            end else if (state == ST_DEV) state <= ST_WORD;
            else if (state == ST_WORD) state <= ST_WRITE;
            else if (state == ST_READ) state <= ST_IDLE;
          end else if ((state == ST_READ) && (bitCnt != 4'd0)) begin
            sdaLow <= ~txR[3'(7 - bitCnt)];
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfgslv_data.sv
`timescale 1ns/1ps
module cfgslv_data import cfgslv_pkg::*; #(
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 5000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              bankNv,
  input  logic              wpIn,
  output logic [BYTE_W-1:0] rdData,
  output logic              busy
);
  localparam int ADDR_W   = BYTE_W;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PAGE_LEN = 1 << PAGE_W;
  localparam int BUSY_W   = $clog2(BUSY_CYCLES + 1);

  logic [BYTE_W-1:0] nvMem [DEPTH];
  logic [BYTE_W-1:0] volMem [DEPTH];
  logic [BYTE_W-1:0] pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0] pageValid;
  logic [ADDR_W-PAGE_W-1:0] pageBase;
  logic pageNv;
  logic [ADDR_W-1:0] ptr;
  logic [BUSY_W-1:0] busyCnt;
  logic nvCommit;

  assign busy     = (busyCnt != '0);
  assign nvCommit = stb.commit && pageNv && (|pageValid) && !wpIn && !busy;
  assign rdData   = bankNv ? nvMem[ptr] : volMem[ptr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      pageBase <= '0;
      pageNv   <= 1'b0;
    end else if (stb.setPtr) begin
      ptr      <= stb.byteVal;
      pageBase <= stb.byteVal[ADDR_W-1:PAGE_W];
      pageNv   <= bankNv;
    end else if (stb.storeByte) begin
      ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
    end else if (stb.advPtr) begin
      ptr <= ptr + ADDR_W'(1);
    end
  end

  for (genvar g = 0; g < PAGE_LEN; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pageValid[g] <= 1'b0;
        pageBuf[g]   <= '0;
      end else if (stb.setPtr || stb.commit || stb.discard) begin
        pageValid[g] <= 1'b0;
      end else if (stb.storeByte && (ptr[PAGE_W-1:0] == PAGE_W'(g))) begin
        pageValid[g] <= 1'b1;
        pageBuf[g]   <= stb.byteVal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        nvMem[i]  <= '0;
        volMem[i] <= '0;
      end
    end else if (stb.commit) begin
      for (int i = 0; i < PAGE_LEN; i++) begin
        if (pageValid[i]) begin
          if (!pageNv) volMem[{pageBase, PAGE_W'(i)}] <= pageBuf[i];
          else if (nvCommit) nvMem[{pageBase, PAGE_W'(i)}] <= pageBuf[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else if (nvCommit) busyCnt <= BUSY_W'(BUSY_CYCLES);
    else if (busy) busyCnt <= busyCnt - BUSY_W'(1);
  end
endmodule

// File: rtl/dualbank_cfg_slave.sv
`timescale 1ns/1ps
module dualbank_cfg_slave import cfgslv_pkg::*; #(
  parameter int         PAGE_W      = 4,
  parameter int         BUSY_CYCLES = 5000000,
  parameter logic [6:0] NV_DEV      = 7'b1101000,
  parameter logic [6:0] VOL_DEV     = 7'b1101001
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wpIn,
  output logic sdaLowOut,
  output logic busyOut
);
  ctrlStb_t stb;
  logic bankNv, sclS;
  logic [BYTE_W-1:0] rdData;

  cfgslv_ctrl #(.NV_DEV(NV_DEV), .VOL_DEV(VOL_DEV)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .busy(busyOut),
    .rdData(rdData), .stb(stb), .bankNv(bankNv), .sdaLow(sdaLowOut), .sclS(sclS)
  );

  cfgslv_data #(.PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .bankNv(bankNv), .wpIn(wpIn),
    .rdData(rdData), .busy(busyOut)
  );
endmodule

// File: rtl/cfgslv_chk.sv
`timescale 1ns/1ps
module cfgslv_chk import cfgslv_pkg::*; #(
  parameter int BUSY_CYCLES = 5000000
) (
  input logic     clk,
  input logic     rstN,
  input logic     sdaLowOut,
  input logic     busyOut,
  input logic     wpIn,
  input ctrlStb_t stb,
  input logic     sclS
);
  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= 0;
    else if (busyOut) busyRun <= busyRun + 1;
    else busyRun <= 0;
  end

  // R6: nothing is acknowledged during the commit interval
  a_r6_quiet_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    busyOut |-> !sdaLowOut);

  // R6: busy begins only on the cycle after a STOP strobe
  a_r6_busy_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyOut) |-> $past(stb.commit));

  // R6: busy interval never outlasts its length
  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= BUSY_CYCLES);

  // R7: a protected commit never starts the interval
  a_r7_protect_blocks: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyOut) |-> !$past(wpIn));

  // R10: the slave starts pulling low only while the clock is low
  a_r10_drive_on_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLowOut) |-> !$past(sclS));
endmodule

bind dualbank_cfg_slave cfgslv_chk #(.BUSY_CYCLES(BUSY_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .sdaLowOut(sdaLowOut), .busyOut(busyOut),
  .wpIn(wpIn), .stb(stb), .sclS(sclS)
);

// File: tb/dualbank_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module dualbank_cfg_slave_tb_top;
  localparam int BUSY = 2000;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic wp = 1'b0;
  logic sdaLowOut, busyOut;
  logic sdaLine;
  assign sdaLine = mSda & ~sdaLowOut;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  logic [7:0] nvM [256];
  logic [7:0] vM [256];
  logic [7:0] expQ [$];
  string tagQ [$];
  logic [7:0] obsByte;
  event obsEvt;

  dualbank_cfg_slave #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .wpIn(wp),
    .sdaLowOut(sdaLowOut), .busyOut(busyOut)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares each byte the master captures with the head of the queue
  initial begin
    forever begin
      @(obsEvt);
      if (expQ.size() == 0) chk(1'b0, "R9", "unexpected read byte", obsByte, 0);
      else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(obsByte == e, t, "read byte", obsByte, e);
      end
    end
  end

  task automatic expect_byte(input logic [7:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b0; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ(); mScl = 1'b1; waitQ(); waitQ(); mScl = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ();
    ack = ~sdaLine;
    waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic sendChk(input logic [7:0] b, input bit expAck, input string tag);
    bit a;
    sendByte(b, a);
    chk(a == expAck, tag, "acknowledge", a, expAck);
  endtask

  task automatic readByte(input bit mAckIt);
    logic [7:0] b;
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); mScl = 1'b1; waitQ(); b[i] = sdaLine; waitQ(); mScl = 1'b0;
    end
    mSda = ~mAckIt; waitQ(); mScl = 1'b1; waitQ(); waitQ(); mScl = 1'b0; waitQ();
    mSda = 1'b1;
    obsByte = b;
    -> obsEvt;
  endtask

  task automatic randRead(input logic [7:0] dev, input logic [7:0] addr, input int n, input string tag);
    busStart();
    sendChk(dev & 8'hFE, 1'b1, tag);
    sendChk(addr, 1'b1, tag);
    busStart();
    sendChk(dev | 8'h01, 1'b1, tag);
    for (int k = 0; k < n; k++) readByte(k != n - 1);
    busStop();
  endtask

  initial begin
    int tRise;
    bit done;
    for (int i = 0; i < 256; i++) begin nvM[i] = 8'h00; vM[i] = 8'h00; end
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(sdaLowOut == 1'b0, "R1", "sda released after reset", sdaLowOut, 0);
    chk(busyOut == 1'b0, "R1", "busy low after reset", busyOut, 0);

    // R3 volatile write of four bytes at 0x10
    busStart();
    sendChk(8'hD2, 1'b1, "R2");
    sendChk(8'h10, 1'b1, "R3");
    sendChk(8'hA1, 1'b1, "R3"); sendChk(8'hB2, 1'b1, "R3");
    sendChk(8'hC3, 1'b1, "R3"); sendChk(8'hD4, 1'b1, "R3");
    busStop();
    vM[8'h10] = 8'hA1; vM[8'h11] = 8'hB2; vM[8'h12] = 8'hC3; vM[8'h13] = 8'hD4;
    chk(sdaLowOut == 1'b0, "R10", "line released after STOP", sdaLowOut, 0);
    repeat (5) @(negedge clk);
    chk(busyOut == 1'b0, "R6", "volatile commit leaves busy low", busyOut, 0);

    // R3 R9 random read of three bytes
    for (int k = 0; k < 3; k++) expect_byte(vM[8'h10 + k], "R3");
    randRead(8'hD2, 8'h10, 3, "R9");

    // R8 current-address read after the pointer stopped at 0x13
    expect_byte(vM[8'h13], "R8");
    busStart(); sendChk(8'hD3, 1'b1, "R8"); readByte(1'b0); busStop();

    // R2 unknown address ignored for the whole frame
    busStart();
    sendChk(8'hA0, 1'b0, "R2");
    sendChk(8'h10, 1'b0, "R2");
    sendChk(8'h55, 1'b0, "R2");
    busStop();
    expect_byte(vM[8'h10], "R2");
    randRead(8'hD2, 8'h10, 1, "R2");

    // R4 seventeen bytes starting at 0x2E wrap inside page 0x20
    busStart();
    sendChk(8'hD2, 1'b1, "R4"); sendChk(8'h2E, 1'b1, "R4");
    for (int k = 0; k < 17; k++) begin
      logic [3:0] lo;
      sendChk(8'h40 + 8'(k), 1'b1, "R4");
      lo = 4'hE + 4'(k);
      vM[{4'h2, lo}] = 8'h40 + 8'(k);
    end
    busStop();
    for (int k = 0; k < 17; k++) expect_byte(vM[8'h20 + k], "R4");
    randRead(8'hD2, 8'h20, 17, "R4");

    // R7 protected persistent write acknowledged but not committed
    wp = 1'b1;
    busStart();
    sendChk(8'hD0, 1'b1, "R7"); sendChk(8'h05, 1'b1, "R7"); sendChk(8'h77, 1'b1, "R7");
    busStop();
    repeat (10) @(negedge clk);
    chk(busyOut == 1'b0, "R7", "no busy under protect", busyOut, 0);
    wp = 1'b0;
    expect_byte(nvM[8'h05], "R7");
    randRead(8'hD0, 8'h05, 1, "R7");

    // R6 persistent write, busy interval and lockout
    busStart();
    sendChk(8'hD0, 1'b1, "R5"); sendChk(8'h05, 1'b1, "R5");
    sendChk(8'h88, 1'b1, "R5"); sendChk(8'h99, 1'b1, "R5");
    mSda = 1'b0; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b1;
    tRise = 0;
    for (int k = 0; k < 40 && tRise == 0; k++) begin
      @(negedge clk);
      if (busyOut) tRise = int'(cyc);
    end
    chk(tRise != 0, "R6", "busy raised after persistent commit", busyOut, 1);
    nvM[8'h05] = 8'h88; nvM[8'h06] = 8'h99;
    waitQ();
    busStart(); sendChk(8'hD0, 1'b0, "R6"); busStop();
    busStart(); sendChk(8'hD2, 1'b0, "R6"); busStop();
    chk(busyOut == 1'b1, "R6", "busy still active", busyOut, 1);
    done = 1'b0;
    for (int k = 0; k < 3 * BUSY && !done; k++) begin
      @(negedge clk);
      if (!busyOut) done = 1'b1;
    end
    chk((int'(cyc) - tRise >= BUSY - 1) && (int'(cyc) - tRise <= BUSY + 1), "R6",
        "busy length", int'(cyc) - tRise, BUSY);
    expect_byte(nvM[8'h05], "R5");
    expect_byte(nvM[8'h06], "R5");
    randRead(8'hD0, 8'h05, 2, "R5");
    expect_byte(vM[8'h05], "R2");
    randRead(8'hD2, 8'h05, 1, "R2");

    // R5 repeated START discards the pending byte but keeps the pointer
    busStart();
    sendChk(8'hD0, 1'b1, "R5"); sendChk(8'h40, 1'b1, "R5"); sendChk(8'h5A, 1'b1, "R5");
    busStart();
    sendChk(8'hD1, 1'b1, "R5");
    expect_byte(nvM[8'h41], "R5");
    readByte(1'b0);
    busStop();
    repeat (10) @(negedge clk);
    chk(busyOut == 1'b0, "R5", "no commit after repeated START", busyOut, 0);
    expect_byte(nvM[8'h40], "R5");
    randRead(8'hD0, 8'h40, 1, "R5");

    // R9 sequential read wraps from 0xFF to 0x00
    busStart();
    sendChk(8'hD2, 1'b1, "R9"); sendChk(8'hFE, 1'b1, "R9");
    sendChk(8'h11, 1'b1, "R9"); sendChk(8'h22, 1'b1, "R9");
    busStop();
    vM[8'hFE] = 8'h11; vM[8'hFF] = 8'h22;
    expect_byte(vM[8'hFE], "R9"); expect_byte(vM[8'hFF], "R9"); expect_byte(vM[8'h00], "R9");
    randRead(8'hD2, 8'hFE, 3, "R9");
    chk(sdaLowOut == 1'b0, "R10", "line released after read", sdaLowOut, 0);

    repeat (20) @(negedge clk);
    chk(expQ.size() == 0, "R9", "all expected bytes observed", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule